// File: doc/BRIEF.md
# Two-Pulse RF Sequence Generator

This block produces a repeating excitation pattern of two timed pulses. A phase accumulator adds a 32-bit increment on every clock and its top eight bits address a computed sine shape, giving a free-running carrier whose frequency is set by the increment. A sequencer walks through four phases: first pulse, gap, second pulse, and rest. Each phase has its own 32-bit length in clock cycles. The two pulse phases open an output window.

Control bits choose how the window is used. With one setting it gates the carrier onto the RF output. With the other it drives a plain trigger level. A rising edge on the start bit launches a pass. The pass either runs once or repeats. A repeat can be told to wait for an external capture FIFO to report empty.

Top module: `rf_pulse_seq`

## Requirements
- R1: The phase accumulator resets to 0 and adds `phase_inc` on every clock edge. It is never cleared between pulses or passes, so the carrier phase is continuous.
- R2: `sine_out` is registered. After an edge it holds shape(a), where a is the top 8 accumulator bits before that edge. With x = a[6:0], m = min(2·x·(128−x), 8191). The value is +m when a[7]=0 and −m when a[7]=1, as a 14-bit signed number. It resets to 0.
- R3: A pass runs its phases in a fixed order: pulse 1 for `len_on1` cycles, gap for `len_gap`, pulse 2 for `len_on2`, then rest for `len_rest`. The window is high during the two pulse phases. The first pulse cycle is the cycle after the clock edge that sees the start edge.
- R4: A length of 0 makes its phase last exactly one cycle. If that phase is a pulse phase, its window stays low.
- R5: A pass starts only on a 0-to-1 change of `ctrl[0]` seen while idle. Holding the bit high does not start a pass. Toggling it during a pass has no effect.
- R6: `ctrl[1]` is read as the rest phase ends. If it is 0 the block goes idle. If it is 1 the next pass follows, and `len_rest` acts only as a minimum spacing.
- R7: `ctrl[2]`=0 puts `sine_out` on `rf_out` while the window is high and 0 otherwise, with `trig_out` low. `ctrl[2]`=1 drives `trig_out` high exactly while the window is high, with `rf_out` held at 0.
- R8: When `ctrl[7]`=1 and `fifo_empty`=0 at the end of rest, the repeat is held with the window low. The first pulse begins the cycle after the edge that sees `fifo_empty`=1. When `ctrl[7]`=0 the repeat does not wait.
- R9: All four lengths are captured as each pass begins. Writes made during a pass apply only from the next pass.
- R10: After reset the block is idle, `trig_out` and `rf_out` are 0, and `sine_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl | input | 8 | Control bits: 0 start, 1 repeat, 2 trigger form, 7 wait for FIFO |
| phase_inc | input | 32 | Accumulator step per clock |
| len_on1 | input | 32 | First pulse length in cycles |
| len_gap | input | 32 | Gap length in cycles |
| len_on2 | input | 32 | Second pulse length in cycles |
| len_rest | input | 32 | Minimum rest length in cycles |
| fifo_empty | input | 1 | Capture FIFO empty flag |
| rf_out | output | 14 | Gated carrier, signed |
| trig_out | output | 1 | Trigger level |
| sine_out | output | 14 | Ungated sine sample, signed |

## Verification
The sine shape is swept over all 256 addresses using a unit step. A second, irregular step then checks the accumulator wrap, so a wrong sign half or a missing clip at the peak shows up as a sample mismatch.

Zero-length phases are checked cycle by cycle. A design that counted 0 as 2^32 would hang, and one that still opened the window would give a spurious trigger cycle.

Other tests cover:
- Restarting on a held start bit, or on a toggle during a pass, which would shift the window.
- Using lengths written mid-pass, which would stretch the current pass.
- Skipping the FIFO hold, which would start the next pulse while `fifo_empty` is still low.

// File: rtl/rf_pulse_seq.sv
`timescale 1ns/1ps
module rf_pulse_seq #(
  parameter int LEN_W  = 32,
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 8,
  parameter int SMP_W  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              ctrl,
  input  logic [ACC_W-1:0]        phase_inc,
  input  logic [LEN_W-1:0]        len_on1,
  input  logic [LEN_W-1:0]        len_gap,
  input  logic [LEN_W-1:0]        len_on2,
  input  logic [LEN_W-1:0]        len_rest,
  input  logic                    fifo_empty,
  output logic signed [SMP_W-1:0] rf_out,
  output logic                    trig_out,
  output logic signed [SMP_W-1:0] sine_out
);
  localparam int HALF = 2 ** (ADDR_W - 1);
  localparam int FS   = 2 ** (SMP_W - 1) - 1;
  localparam int SH   = SMP_W - 1 - 2 * (ADDR_W - 2);

  localparam logic [2:0] S_IDLE = 3'd0, S_ON1 = 3'd1, S_GAP = 3'd2,
                         S_ON2  = 3'd3, S_REST = 3'd4, S_HOLD = 3'd5;

  function automatic logic signed [SMP_W-1:0] shape(input logic [ADDR_W-1:0] a);
    int x, y;
    x = int'(a[ADDR_W-2:0]);
    y = (x * (HALF - x)) <<< SH;
    if (y > FS) y = FS;
    return a[ADDR_W-1] ? SMP_W'(-y) : SMP_W'(y);
  endfunction

  logic [ACC_W-1:0]        acc;
  logic signed [SMP_W-1:0] sine_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc    <= '0;
      sine_q <= '0;
    end else begin
      acc    <= acc + phase_inc;
      sine_q <= shape(acc[ACC_W-1 -: ADDR_W]);
    end

  logic [2:0]       st;
  logic [LEN_W-1:0] cnt, l_gap, l_on2, l_rest;
  logic             z_on1, z_on2, go_q;

  wire go_edge   = ctrl[0] & ~go_q;
  wire last      = (cnt[LEN_W-1:1] == '0);
  wire repeat_ok = ~ctrl[7] | fifo_empty;
  wire load      = (st == S_IDLE && go_edge) ||
                   (st == S_REST && last && ctrl[1] && repeat_ok) ||
                   (st == S_HOLD && repeat_ok);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      l_gap  <= '0;
      l_on2  <= '0;
      l_rest <= '0;
      z_on1  <= 1'b1;
      z_on2  <= 1'b1;
    end else if (load) begin
      l_gap  <= len_gap;
      l_on2  <= len_on2;
      l_rest <= len_rest;
      z_on1  <= (len_on1 == '0);
      z_on2  <= (len_on2 == '0);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      go_q <= 1'b0;
    end else begin
      go_q <= ctrl[0];
      if (load) begin
        st  <= S_ON1;
        cnt <= len_on1;
      end else begin
        case (st)
          S_ON1:  if (last) begin st <= S_GAP;  cnt <= l_gap;  end else cnt <= cnt - 1'b1;
          S_GAP:  if (last) begin st <= S_ON2;  cnt <= l_on2;  end else cnt <= cnt - 1'b1;
          S_ON2:  if (last) begin st <= S_REST; cnt <= l_rest; end else cnt <= cnt - 1'b1;
          S_REST: if (last) st <= ctrl[1] ? S_HOLD : S_IDLE; else cnt <= cnt - 1'b1;
          default: ;
        endcase
      end
    end

  wire win = (st == S_ON1 && !z_on1) || (st == S_ON2 && !z_on2);

  assign trig_out = win & ctrl[2];
  assign rf_out   = (win & ~ctrl[2]) ? sine_q : '0;
  assign sine_out = sine_q;
endmodule

module rf_pulse_seq_chk (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         ctrl,
  input logic               fifo_empty,
  input logic [31:0]        phase_inc,
  input logic [31:0]        acc,
  input logic [2:0]         st,
  input logic [31:0]        cnt,
  input logic               go_q,
  input logic               trig_out,
  input logic signed [13:0] rf_out,
  input logic signed [13:0] sine_out
);
  a_r1_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> acc == $past(acc) + $past(phase_inc));
  a_r2_sine_range: assert property (@(posedge clk) disable iff (!rst_n)
    sine_out >= -14'sd8191 && sine_out <= 14'sd8191);
  a_r7_trig_excl: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> rf_out == 14'sd0);
  a_r5_no_level_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !(ctrl[0] && !go_q)) |=> st == 3'd0);
  a_r6_single_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && cnt <= 32'd1 && !ctrl[1]) |=> st == 3'd0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5 && ctrl[7] && !fifo_empty) |=> (st == 3'd5 && !trig_out));
endmodule

bind rf_pulse_seq rf_pulse_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .fifo_empty(fifo_empty),
  .phase_inc(phase_inc), .acc(acc), .st(st), .cnt(cnt), .go_q(go_q),
  .trig_out(trig_out), .rf_out(rf_out), .sine_out(sine_out));

// File: tb/sim_rf_pulse_seq.sv
`timescale 1ns/1ps
module sim_rf_pulse_seq;
  logic clk = 0, rst_n = 0;
  logic [7:0] ctrl = '0;
  logic [31:0] phase_inc = '0, len_on1 = '0, len_gap = '0, len_on2 = '0, len_rest = '0;
  logic fifo_empty = 1'b1;
  logic signed [13:0] rf_out, sine_out;
  logic trig_out;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0]  nx_ctrl;
  logic [31:0] nx_l [4];

  always #5 clk = ~clk;

  rf_pulse_seq u0 (.clk(clk), .rst_n(rst_n), .ctrl(ctrl), .phase_inc(phase_inc),
    .len_on1(len_on1), .len_gap(len_gap), .len_on2(len_on2), .len_rest(len_rest),
    .fifo_empty(fifo_empty), .rf_out(rf_out), .trig_out(trig_out), .sine_out(sine_out));

  function automatic int ref_shape(input int a);
    int x, m;
    x = a % 128;
    m = 2 * x * (128 - x);
    if (m > 8191) m = 8191;
    return (a >= 128) ? -m : m;
  endfunction

  logic [31:0] m_acc;
  int m_sine;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_acc <= 0; m_sine <= 0; end
    else begin m_acc <= m_acc + phase_inc; m_sine <= ref_shape(int'(m_acc[31:24])); end

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_lens(input int a, input int b, input int c, input int d);
    len_on1 = a; len_gap = b; len_on2 = c; len_rest = d;
  endtask

  task automatic start_seq();
    ctrl[0] = 1'b0;
    @(negedge clk);
    ctrl[0] = 1'b1;
    @(negedge clk);
  endtask

  // Checks one pass; current negedge is the first cycle of pulse 1.
  // poke 1: apply nx_* after first cycle; poke 2: toggle start bit mid-pass (R5)
  task automatic check_pass(input int a, input int b, input int c, input int d,
                            input int poke, input string req);
    int dd [4];
    int idx;
    dd = '{a, b, c, d};
    idx = 0;
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < ((dd[p] == 0) ? 1 : dd[p]); k++) begin
        bit w;
        w = ((p == 0) || (p == 2)) && (dd[p] != 0);
        if (ctrl[2]) begin
          chk(int'(trig_out), int'(w), {req, " trig window"});
          chk(int'(rf_out), 0, {req, " R7 rf idle in trigger form"});
        end else begin
          chk(int'(trig_out), 0, {req, " R7 trig low in carrier form"});
          chk(int'(rf_out), w ? m_sine : 0, {req, " R7 gated carrier"});
          chk(int'(sine_out), m_sine, {req, " R1 carrier continuity"});
        end
        if (poke == 1 && idx == 0) begin
          ctrl = nx_ctrl;
          set_lens(nx_l[0], nx_l[1], nx_l[2], nx_l[3]);
        end
        if (poke == 2 && idx == 0) ctrl[0] = 1'b0;
        if (poke == 2 && idx == 2) ctrl[0] = 1'b1;
        idx++;
        @(negedge clk);
      end
    end
  endtask

  task automatic idle_chk(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(int'(trig_out), 0, {req, " trig low"});
      chk(int'(rf_out), 0, {req, " rf zero"});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(int'(trig_out), 0, "R10 trig in reset");
    chk(int'(rf_out), 0, "R10 rf in reset");
    chk(int'(sine_out), 0, "R10 sine in reset");
    rst_n = 1'b1;
    idle_chk(3, "R10 idle after reset");

    // R2: exhaustive address sweep, then R1 irregular step wrap
    phase_inc = 32'h0100_0000;
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      chk(int'(sine_out), m_sine, "R2 sine sweep");
    end
    phase_inc = 32'h0123_4567;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      chk(int'(sine_out), m_sine, "R1 accumulator step");
    end

    // R3: trigger form, single pass, then R5/R6 no restart while held high
    ctrl = 8'b0000_0100;
    set_lens(5, 3, 4, 6);
    start_seq();
    check_pass(5, 3, 4, 6, 0, "R3");
    idle_chk(12, "R5 R6 single pass ends, held start level");

    // R4: zero-length phases
    set_lens(0, 2, 0, 3);
    start_seq();
    check_pass(0, 2, 0, 3, 0, "R4 zero pulses");
    idle_chk(4, "R4 after");
    set_lens(2, 0, 3, 0);
    start_seq();
    check_pass(2, 0, 3, 0, 0, "R4 zero gap and rest");
    idle_chk(4, "R4 after");

    // R5: start bit toggled during a pass is ignored
    set_lens(6, 2, 5, 3);
    start_seq();
    check_pass(6, 2, 5, 3, 2, "R5 toggle mid-pass");
    idle_chk(10, "R5 no restart");

    // R9 + R6: continuous, mid-pass writes used by next pass, then stop
    ctrl = 8'b0000_0110;
    set_lens(3, 2, 3, 2);
    nx_ctrl = 8'b0000_0111; nx_l = '{2, 4, 1, 3};
    start_seq();
    check_pass(3, 2, 3, 2, 1, "R9 old lengths kept");
    nx_ctrl = 8'b0000_0101; nx_l = '{2, 4, 1, 3};
    check_pass(2, 4, 1, 3, 1, "R9 R6 new lengths on repeat");
    idle_chk(10, "R6 stop after repeat bit cleared");

    // R8: wait for FIFO empty
    ctrl = 8'b1000_0110;
    fifo_empty = 1'b0;
    set_lens(2, 2, 2, 2);
    start_seq();
    check_pass(2, 2, 2, 2, 0, "R8 first pass");
    idle_chk(8, "R8 held while fifo not empty");
    fifo_empty = 1'b1;
    @(negedge clk);
    nx_ctrl = 8'b1000_0101; nx_l = '{2, 2, 2, 2};
    check_pass(2, 2, 2, 2, 1, "R8 released pass");
    idle_chk(6, "R8 stop");

    // R8: no wait when ctrl[7]=0 even with fifo not empty
    ctrl = 8'b0000_0110;
    fifo_empty = 1'b0;
    set_lens(3, 1, 2, 1);
    start_seq();
    check_pass(3, 1, 2, 1, 0, "R8 no-wait first");
    nx_ctrl = 8'b0000_0101; nx_l = '{3, 1, 2, 1};
    check_pass(3, 1, 2, 1, 1, "R8 no-wait back to back");
    idle_chk(5, "R8 no-wait stop");
    fifo_empty = 1'b1;

    // R7: carrier form with gated sine
    ctrl = 8'b0000_0000;
    phase_inc = 32'h0345_6789;
    set_lens(7, 3, 9, 4);
    start_seq();
    check_pass(7, 3, 9, 4, 0, "R7 carrier pass");
    idle_chk(5, "R7 carrier idle");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule